// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Processor Core

This block is an integer core for an eight-register machine. It overlaps instructions across five stages: fetch, decode, execute, memory access and writeback. Instruction and data memories are outside the block and have separate ports. Both memories are read combinationally within the cycle that presents the address. Four edge-triggered stage registers sit between the stages. Each one carries the instruction field bits forward with the values that the later stages need. Every later stage decodes its own controls from the opcode field it receives.

The core executes add, nor, load word, store word, branch-if-equal and no-operation. It has no forwarding, no hazard detection and no stall logic. Software must place enough no-operations between a producer and its consumer. A branch is resolved in the memory stage, and that decision steers the fetch address multiplexer. When a branch is taken, the three instructions fetched behind it are turned into no-operations. The core raises a one-cycle strobe for every real instruction that completes writeback.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, and afterwards, the following hold. The fetch address starts at 0. All four stage registers hold a no-operation. All eight registers read 0. `dmem_en` stays low for the first three cycles after reset. `retire_o` stays low for the first four cycles after reset.
- R2: The instruction fields are fixed at these positions:
  - opcode in bits 24:22, with 0 add, 1 nor, 2 load, 3 store, 4 branch-if-equal and 7 no-operation;
  - first source register in bits 21:19;
  - second source register in bits 18:16;
  - destination register for add and nor in bits 2:0;
  - signed 16-bit offset in bits 15:0.
  Opcodes 5 and 6 behave as no-operations.
- R3: Add writes the sum of the two source registers to the register in bits 2:0. Nor writes the bitwise NOR of the two source registers to the register in bits 2:0.
- R4: Load raises `dmem_en` with `dmem_we` low. It drives the address first-source + sign-extended offset and writes `dmem_rdata` into the register named by bits 18:16.
- R5: Store raises `dmem_en` and `dmem_we`. It drives the address first-source + sign-extended offset and drives the second source register's value on `dmem_wdata`. `dmem_we` is never high without `dmem_en`.
- R6: When a branch-if-equal finds its two sources equal, the fetch address in the next cycle is branch address + 1 + offset. The three younger instructions then in flight perform no memory access and do not retire.
- R7: When a branch-if-equal finds its sources unequal, fetch continues in sequence.
- R8: A register written in writeback is seen by a decode-stage read of the same register in the same cycle. Two no-operations between producer and consumer are therefore enough.
- R9: `retire_o` is high for one cycle for each instruction other than a no-operation that is in writeback. The first instruction after reset retires in cycle 5.
- R10: When no branch is taken, `imem_addr` advances by one every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | XLEN | Fetch word address |
| imem_ins | input | 25 | Instruction field bits read at `imem_addr` |
| dmem_en | output | 1 | Data memory access this cycle |
| dmem_we | output | 1 | Data memory write (store) |
| dmem_addr | output | XLEN | Data word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data read at `dmem_addr` |
| retire_o | output | 1 | One pulse per completed real instruction |

## Verification
The assertions assume that the instruction stream respects the missing hazard logic. Software must leave at least two no-operations between a register write and any later read of that register. Under that assumption, the fetch address sequence and the memory port activity follow only from the redirect decision and the reset. The stimulus program puts exactly two no-operations between each dependent pair, so the same-cycle bypass is exercised at its tightest spacing. No other instruction reads a register that is still in flight. Stores placed in the branch shadow would show up as unexpected memory accesses if the squash failed.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int IW   = 25;
  localparam int NREG = 8;
  localparam int RIW  = $clog2(NREG);

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_NOR = 3'd1;
  localparam logic [2:0] OP_LW  = 3'd2;
  localparam logic [2:0] OP_SW  = 3'd3;
  localparam logic [2:0] OP_BEQ = 3'd4;
  localparam logic [2:0] OP_NOP = 3'd7;

  localparam logic [IW-1:0] NOP_WORD = {OP_NOP, 22'd0};

  function automatic logic [2:0] f_opc(input logic [IW-1:0] w);
    return w[24:22];
  endfunction
  function automatic logic [RIW-1:0] f_ra(input logic [IW-1:0] w);
    return w[21:19];
  endfunction
  function automatic logic [RIW-1:0] f_rb(input logic [IW-1:0] w);
    return w[18:16];
  endfunction
  function automatic logic [RIW-1:0] f_rd(input logic [IW-1:0] w);
    return w[2:0];
  endfunction
  function automatic logic [15:0] f_off(input logic [IW-1:0] w);
    return w[15:0];
  endfunction
  function automatic logic f_real(input logic [IW-1:0] w);
    logic [2:0] o;
    o = w[24:22];
    return (o == OP_ADD) || (o == OP_NOR) || (o == OP_LW) ||
           (o == OP_SW) || (o == OP_BEQ);
  endfunction
endpackage

// File: rtl/p5_regfile.sv
module p5_regfile
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIW-1:0]  ra_i,
  input  logic [RIW-1:0]  rb_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  input  logic            we_i,
  input  logic [RIW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] rf_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wen;
    assign wen = we_i && (wa_i == RIW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rf_q[g] <= '0;
      else if (wen) rf_q[g] <= wd_i;
    end
  end

  // same-cycle write wins over the stored copy
  always_comb begin
    a_o = (we_i && wa_i == ra_i) ? wd_i : rf_q[ra_i];
    b_o = (we_i && wa_i == rb_i) ? wd_i : rf_q[rb_i];
  end
endmodule

// File: rtl/p5_exec.sv
module p5_exec
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      opc_i,
  input  logic [15:0]     off_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] pc1_i,
  output logic [XLEN-1:0] res_o,
  output logic [XLEN-1:0] tgt_o,
  output logic            eq_o
);
  logic [XLEN-1:0] sext;
  assign sext = {{(XLEN-16){off_i[15]}}, off_i};

  always_comb begin
    unique case (opc_i)
      OP_NOR:        res_o = ~(a_i | b_i);
      OP_LW, OP_SW:  res_o = a_i + sext;
      default:       res_o = a_i + b_i;
    endcase
    tgt_o = pc1_i + sext;
    eq_o  = (a_i == b_i);
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [IW-1:0]   imem_ins,
  output logic            dmem_en,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            retire_o
);
  // fetch
  logic [XLEN-1:0] pc_q, pc_d;
  // IF/ID
  logic [IW-1:0]   fd_ir_q, fd_ir_d;
  logic [XLEN-1:0] fd_pc1_q, fd_pc1_d;
  // ID/EX
  logic [IW-1:0]   dx_ir_q, dx_ir_d;
  logic [XLEN-1:0] dx_pc1_q, dx_a_q, dx_b_q;
  // EX/MEM
  logic [IW-1:0]   xm_ir_q, xm_ir_d;
  logic [XLEN-1:0] xm_res_q, xm_b_q, xm_tgt_q;
  logic            xm_eq_q;
  // MEM/WB
  logic [IW-1:0]   mw_ir_q;
  logic [XLEN-1:0] mw_res_q, mw_ld_q;

  logic [XLEN-1:0] rd_a, rd_b, ex_res, ex_tgt;
  logic            ex_eq;
  logic            redirect;
  logic            wb_we;
  logic [RIW-1:0]  wb_addr;
  logic [XLEN-1:0] wb_data;
  logic [2:0]      xm_opc, mw_opc;

  assign xm_opc = f_opc(xm_ir_q);
  assign mw_opc = f_opc(mw_ir_q);

  // decode: register read, with writeback bypass inside
  p5_regfile #(.XLEN(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_i  (f_ra(fd_ir_q)),
    .rb_i  (f_rb(fd_ir_q)),
    .a_o   (rd_a),
    .b_o   (rd_b),
    .we_i  (wb_we),
    .wa_i  (wb_addr),
    .wd_i  (wb_data)
  );

  // execute
  p5_exec #(.XLEN(XLEN)) u_ex (
    .opc_i (f_opc(dx_ir_q)),
    .off_i (f_off(dx_ir_q)),
    .a_i   (dx_a_q),
    .b_i   (dx_b_q),
    .pc1_i (dx_pc1_q),
    .res_o (ex_res),
    .tgt_o (ex_tgt),
    .eq_o  (ex_eq)
  );

  // memory stage controls
  assign redirect   = (xm_opc == OP_BEQ) && xm_eq_q;
  assign dmem_en    = (xm_opc == OP_LW) || (xm_opc == OP_SW);
  assign dmem_we    = (xm_opc == OP_SW);
  assign dmem_addr  = xm_res_q;
  assign dmem_wdata = xm_b_q;

  // writeback controls
  assign wb_we    = (mw_opc == OP_ADD) || (mw_opc == OP_NOR) || (mw_opc == OP_LW);
  assign wb_addr  = (mw_opc == OP_LW) ? f_rb(mw_ir_q) : f_rd(mw_ir_q);
  assign wb_data  = (mw_opc == OP_LW) ? mw_ld_q : mw_res_q;
  assign retire_o = f_real(mw_ir_q);

  assign imem_addr = pc_q;

  // next state
  always_comb begin
    pc_d     = redirect ? xm_tgt_q : pc_q + 1'b1;
    fd_ir_d  = redirect ? NOP_WORD : imem_ins;
    fd_pc1_d = pc_q + 1'b1;
    dx_ir_d  = redirect ? NOP_WORD : fd_ir_q;
    xm_ir_d  = redirect ? NOP_WORD : dx_ir_q;
  end

  // control-carrying registers (reset to no-operation)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      fd_ir_q <= NOP_WORD;
      dx_ir_q <= NOP_WORD;
      xm_ir_q <= NOP_WORD;
      mw_ir_q <= NOP_WORD;
    end else begin
      pc_q    <= pc_d;
      fd_ir_q <= fd_ir_d;
      dx_ir_q <= dx_ir_d;
      xm_ir_q <= xm_ir_d;
      mw_ir_q <= xm_ir_q;
    end
  end

  // data payload registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_pc1_q <= '0;
      dx_pc1_q <= '0;
      dx_a_q   <= '0;
      dx_b_q   <= '0;
      xm_res_q <= '0;
      xm_b_q   <= '0;
      xm_tgt_q <= '0;
      xm_eq_q  <= 1'b0;
      mw_res_q <= '0;
      mw_ld_q  <= '0;
    end else begin
      fd_pc1_q <= fd_pc1_d;
      dx_pc1_q <= fd_pc1_q;
      dx_a_q   <= rd_a;
      dx_b_q   <= rd_b;
      xm_res_q <= ex_res;
      xm_b_q   <= dx_b_q;
      xm_tgt_q <= ex_tgt;
      xm_eq_q  <= ex_eq;
      mw_res_q <= xm_res_q;
      mw_ld_q  <= dmem_rdata;
    end
  end
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic            dmem_en,
  input logic            dmem_we,
  input logic            retire_o,
  input logic            redirect,
  input logic [XLEN-1:0] tgt
);
  logic [2:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 3'd7) since_q <= since_q + 1'b1;
  end

  a_r1_no_early_access: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < 3'd3) |-> !dmem_en);
  a_r1_no_early_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < 3'd4) |-> !retire_o);
  a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> dmem_en);
  a_r10_sequential_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> (imem_addr == $past(imem_addr) + 1'b1));
  a_r6_fetch_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (imem_addr == $past(tgt)));
  a_r6_shadow_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !dmem_en);
  a_r6_shadow_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> ##1 !retire_o);
endmodule

bind pipe5_core pipe5_core_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_en   (dmem_en),
  .dmem_we   (dmem_we),
  .retire_o  (retire_o),
  .redirect  (redirect),
  .tgt       (xm_tgt_q)
);

// File: tb/sim_pipe5_core.sv
`timescale 1ns/1ps
module sim_pipe5_core;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [XLEN-1:0] imem_addr;
  logic [24:0]     imem_ins;
  logic            dmem_en, dmem_we;
  logic [XLEN-1:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic            retire_o;

  logic [31:0] imem [32];
  logic [31:0] dmem [64];

  int nchk = 0, nfail = 0, cyc = 0, rcnt = 0;
  bit final_seen = 0, done = 0;

  typedef struct { bit st; logic [31:0] addr; logic [31:0] data; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pipe5_core #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_ins(imem_ins),
    .dmem_en(dmem_en), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .retire_o(retire_o));

  assign imem_ins   = imem[imem_addr[4:0]][24:0];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    if (rst_n && dmem_en && dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int ra, input int rb, input int off);
    return (32'(op) << 22) | (32'(ra) << 19) | (32'(rb) << 16) | (32'(off) & 32'hFFFF);
  endfunction

  task automatic push_exp(input bit st, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    e.st = st; e.addr = a; e.data = d;
    q.push_back(e);
  endtask

  // monitor: scoreboard for memory traffic and retire accounting
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (retire_o) begin
        rcnt++;
        if (rcnt == 1) chk(cyc == 4, "R9 first retire in cycle 5", cyc + 1, 5);
      end
      if (final_seen) begin
        chk(rcnt == 11, "R9 retire count", rcnt, 11);
        done = 1;
      end
      if (cyc >= 1 && cyc <= 3) chk(imem_addr == cyc, "R10 fetch step", imem_addr, cyc);
      if (cyc == 14) chk(imem_addr == 15, "R6 taken branch target", imem_addr, 15);
      if (dmem_en && !done) begin
        if (q.size() == 0) begin
          chk(0, "R6 unexpected memory access", dmem_addr, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(dmem_we == e.st, e.st ? "R5 store kind" : "R4 load kind", dmem_we, e.st);
          chk(dmem_addr == e.addr, e.st ? "R5 store address" : "R4 load address", dmem_addr, e.addr);
          if (e.st) chk(dmem_wdata == e.data, "R3/R5/R8 store data", dmem_wdata, e.data);
          if (q.size() == 0) final_seen = 1;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) imem[i] = enc(7, 0, 0, 0);
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    dmem[10] = 32'd5;
    dmem[11] = 32'd7;
    // R2 encodings: op 0 add,1 nor,2 lw,3 sw,4 beq,7 noop
    imem[0]  = enc(2, 0, 1, 10);      // r1 = 5
    imem[1]  = enc(2, 0, 2, 11);      // r2 = 7
    imem[4]  = enc(0, 1, 2, 3);       // r3 = 12, R8 two-noop spacing
    imem[5]  = enc(1, 1, 2, 4);       // r4 = ~(5|7)
    imem[8]  = enc(3, 0, 3, 20);
    imem[9]  = enc(3, 0, 4, 21);
    imem[10] = enc(4, 1, 1, 4);       // taken -> 15
    for (int i = 11; i <= 14; i++) imem[i] = enc(3, 0, 1, 30); // shadow stores
    imem[15] = enc(4, 1, 2, 5);       // R7 not taken
    imem[16] = enc(3, 0, 2, 22);
    imem[17] = enc(2, 3, 5, -2);      // r5 = mem[10]
    imem[20] = enc(3, 1, 5, 18);      // mem[23] = r5
    imem[21] = enc(4, 0, 0, -1);      // spin

    push_exp(0, 10, 0);
    push_exp(0, 11, 0);
    push_exp(1, 20, 32'd12);
    push_exp(1, 21, 32'hFFFF_FFF8);
    push_exp(1, 22, 32'd7);
    push_exp(0, 10, 0);
    push_exp(1, 23, 32'd5);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(imem_addr == 0, "R1 reset fetch address", imem_addr, 0);
    chk(retire_o == 0, "R1 reset retire", retire_o, 0);
    chk(dmem_en == 0, "R1 reset memory idle", dmem_en, 0);
    #1 rst_n = 1'b1;

    for (int i = 0; i < 2000 && !done; i++) @(posedge clk);
    if (!done) chk(0, "R9 watchdog expired", cyc, 0);
    @(negedge clk);
    chk(q.size() == 0, "R5 all expected accesses seen", q.size(), 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule